// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block turns one read or write start into the series of column addresses that an SDRAM burst visits. It holds a burst setting that is loaded from the address-bus value of a mode-register load. The setting gives the burst length, the wrap order and the write-burst mode. When a start arrives, the block freezes that setting for the burst. It then issues one column address per accepted transfer, flags the final beat and pulses a completion strobe.

The address output is a valid/ready stream. The block raises `col_valid` with an address. A beat counts as transferred only in a cycle where `col_ready` is also high. While `col_ready` is low, the address and the last-beat flag hold steady and the burst does not advance. The start, mode-load, done and error pins are plain strobes with no handshake. The `ORG` parameter picks the device organization: 0 gives 10 column bits, 1 gives 9 and 2 gives 8. The page length follows from it as 1024, 512 or 256 columns.

Top module: `burst_col_seq`

## Requirements
- R1: On a mode load, `mrs_addr[2:0]` selects the burst length: 000 is 1 beat, 001 is 2, 010 is 4, 011 is 8, 111 is a full page, and any other code is 1 beat. `mrs_addr[3]` selects the order, 0 for sequential and 1 for interleaved.
- R2: In sequential order, the address bits inside the burst block count upward from the start value and wrap inside the block. For example, length 4 starting at low bits 1 gives 1,2,3,0.
- R3: In interleaved order, beat i carries the start column XOR i. For example, length 8 starting at low bits 5 gives 5,4,7,6,1,0,3,2.
- R4: For lengths 2, 4 and 8, the column bits above the burst block keep their start values on every beat.
- R5: A sequential full-page burst runs for exactly 2^COL_W beats. It increments the whole column from the start and wraps from all ones to zero.
- R6: A start under full page with interleaved order issues no beat. Instead, `cfg_error` pulses high for one cycle, in the cycle after the start is sampled.
- R7: Single-write mode is selected when `mrs_addr[9]`=1 and bits 7, 8 and 10–13 are all zero. In this mode a write start (`start_write`=1) gives one beat at the start column, while reads keep the programmed length. Any other value of those bits gives normal mode.
- R8: The first address is valid in the cycle after the start is sampled. `col_last` is high only on the final beat. `burst_done` pulses for one cycle, in the cycle after the final beat is transferred.
- R9: While `col_valid` is high and `col_ready` is low, `col_addr` and `col_last` hold and no beat is consumed.
- R10: A start that arrives while `col_valid` is high is ignored. The running burst continues unchanged and no further burst follows it.
- R11: After reset, `col_valid`, `col_last`, `burst_done` and `cfg_error` are low, and the setting is 1 beat, sequential, normal mode.
- R12: A mode load during a burst does not change that burst's addresses or length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mrs_load | input | 1 | Mode-register load strobe |
| mrs_addr | input | ADDR_W | Address-bus value that comes with the mode load |
| start | input | 1 | Burst start strobe |
| start_write | input | 1 | 1 when the burst being started is a write |
| start_col | input | COL_W | Starting column address |
| col_ready | input | 1 | Consumer accepts the current address |
| col_addr | output | COL_W | Current column address |
| col_valid | output | 1 | `col_addr` carries a burst beat |
| col_last | output | 1 | Current beat is the final one |
| burst_done | output | 1 | One-cycle pulse after the final beat is transferred |
| cfg_error | output | 1 | One-cycle pulse when a start is refused (full page with interleaved order) |

## Verification
Every start is sampled on a rising edge. The first address, or for a refused start the error pulse, appears after that same edge. Each later address appears after the edge on which the previous beat was transferred, and the done pulse appears one edge after the final transfer. The bench samples outputs on the falling edge between rising edges. A scoreboard pops one expected address each time valid and ready are both high there. The done and stall-hold checks compare against what the bench saw at the previous falling edge, so each result is checked in exactly the cycle it is due.

// File: rtl/burst_pkg.sv
package burst_pkg;

  // Burst length selection after decode
  typedef enum logic [2:0] {
    BL_1    = 3'd0,
    BL_2    = 3'd1,
    BL_4    = 3'd2,
    BL_8    = 3'd3,
    BL_PAGE = 3'd4
  } burst_len_e;

  typedef struct packed {
    burst_len_e len;
    logic       interleave;
    logic       single_write;
  } burst_cfg_t;

  localparam burst_cfg_t CFG_RESET = '{len: BL_1, interleave: 1'b0, single_write: 1'b0};

  // Column width for organization code 0 (x4), 1 (x8), 2 (x16)
  function automatic int col_width(int org);
    case (org)
      0:       return 10;
      1:       return 9;
      default: return 8;
    endcase
  endfunction

  // Mode-bus decode of bits 13..0 into a burst setting
  function automatic burst_cfg_t decode_mode(logic [13:0] a);
    burst_cfg_t c;
    case (a[2:0])
      3'b000:  c.len = BL_1;
      3'b001:  c.len = BL_2;
      3'b010:  c.len = BL_4;
      3'b011:  c.len = BL_8;
      3'b111:  c.len = BL_PAGE;
      default: c.len = BL_1;
    endcase
    c.interleave   = a[3];
    c.single_write = a[9] && (a[8:7] == 2'b00) && (a[13:10] == 4'b0000);
    return c;
  endfunction

endpackage

// File: rtl/burst_mode_reg.sv
module burst_mode_reg
  import burst_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr,
  output burst_cfg_t        cfg
);

  logic unused_mode_bits;
  assign unused_mode_bits = ^addr[6:4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= CFG_RESET;
    end else if (load) begin
      cfg <= decode_mode(addr[13:0]);
    end
  end

endmodule

// File: rtl/burst_beat_ctrl.sv
module burst_beat_ctrl
  import burst_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_write,
  input  burst_cfg_t       cfg,
  input  logic             ready,
  output logic             capture,
  output logic             capture_il,
  output logic             active,
  output logic [COL_W-1:0] idx,
  output logic [COL_W-1:0] len_m1,
  output logic             last,
  output logic             done,
  output logic             err
);

  burst_len_e       eff_len;
  logic [COL_W-1:0] len_m1_next;
  logic             refuse;
  logic             accept;
  logic             xfer;

  always_comb begin
    eff_len = cfg.len;
    if (start_write && cfg.single_write) eff_len = BL_1;
    case (eff_len)
      BL_2:    len_m1_next = COL_W'(1);
      BL_4:    len_m1_next = COL_W'(3);
      BL_8:    len_m1_next = COL_W'(7);
      BL_PAGE: len_m1_next = '1;
      default: len_m1_next = '0;
    endcase
  end

  assign refuse     = (eff_len == BL_PAGE) && cfg.interleave;
  assign accept     = start && !active;
  assign capture    = accept && !refuse;
  assign capture_il = cfg.interleave;
  assign last       = active && (idx == len_m1);
  assign xfer       = active && ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
      len_m1 <= '0;
      done   <= 1'b0;
      err    <= 1'b0;
    end else begin
      done <= xfer && last;
      err  <= accept && refuse;
      if (capture) begin
        active <= 1'b1;
        idx    <= '0;
        len_m1 <= len_m1_next;
      end else if (xfer) begin
        if (last) begin
          active <= 1'b0;
        end else begin
          idx <= idx + COL_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic             capture_il,
  input  logic [COL_W-1:0] start_col,
  input  logic [COL_W-1:0] idx,
  input  logic [COL_W-1:0] mask,
  output logic [COL_W-1:0] addr
);

  logic [COL_W-1:0] base;
  logic             il;
  logic [COL_W-1:0] sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base <= '0;
      il   <= 1'b0;
    end else if (capture) begin
      base <= start_col;
      il   <= capture_il;
    end
  end

  assign sum = base + idx;

  // Bits inside the block follow the order; bits above it stay at the base
  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    assign addr[b] = mask[b] ? (il ? (base[b] ^ idx[b]) : sum[b]) : base[b];
  end

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_pkg::*;
#(
  parameter int ORG    = 2,
  parameter int ADDR_W = 14,
  localparam int COL_W = col_width(ORG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mrs_load,
  input  logic [ADDR_W-1:0] mrs_addr,
  input  logic              start,
  input  logic              start_write,
  input  logic [COL_W-1:0]  start_col,
  input  logic              col_ready,
  output logic [COL_W-1:0]  col_addr,
  output logic              col_valid,
  output logic              col_last,
  output logic              burst_done,
  output logic              cfg_error
);

  burst_cfg_t       cfg;
  logic             capture;
  logic             capture_il;
  logic [COL_W-1:0] idx;
  logic [COL_W-1:0] len_m1;

  burst_mode_reg #(.ADDR_W(ADDR_W)) u_mode (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (mrs_load),
    .addr  (mrs_addr),
    .cfg   (cfg)
  );

  burst_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .start_write (start_write),
    .cfg         (cfg),
    .ready       (col_ready),
    .capture     (capture),
    .capture_il  (capture_il),
    .active      (col_valid),
    .idx         (idx),
    .len_m1      (len_m1),
    .last        (col_last),
    .done        (burst_done),
    .err         (cfg_error)
  );

  burst_addr_gen #(.COL_W(COL_W)) u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture    (capture),
    .capture_il (capture_il),
    .start_col  (start_col),
    .idx        (idx),
    .mask       (len_m1),
    .addr       (col_addr)
  );

endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             col_ready,
  input logic [COL_W-1:0] col_addr,
  input logic             col_valid,
  input logic             col_last,
  input logic             burst_done,
  input logic             cfg_error
);

  p_last_in_beat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    col_last |-> col_valid);

  p_done_follows_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && col_ready && col_last) |=> burst_done);

  p_done_needs_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |-> $past(col_valid && col_ready && col_last));

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !col_ready) |=> (col_valid && $stable(col_addr) && $stable(col_last)));

  p_refuse_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_error |-> !col_valid);

  p_burst_runs_on_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !(col_ready && col_last)) |=> col_valid);

endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .col_ready  (col_ready),
  .col_addr   (col_addr),
  .col_valid  (col_valid),
  .col_last   (col_last),
  .burst_done (burst_done),
  .cfg_error  (cfg_error)
);

// File: tb/burst_col_seq_bench.sv
`timescale 1ns/1ps
module burst_col_seq_bench;
  localparam int ORG  = 2;
  localparam int COLW = burst_pkg::col_width(ORG);
  localparam int PAGE = 1 << COLW;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            mrs_load = 1'b0;
  logic [13:0]     mrs_addr = '0;
  logic            start = 1'b0;
  logic            start_write = 1'b0;
  logic [COLW-1:0] start_col = '0;
  logic            col_ready = 1'b1;
  logic [COLW-1:0] col_addr;
  logic            col_valid, col_last, burst_done, cfg_error;

  burst_col_seq #(.ORG(ORG), .ADDR_W(14)) u_burst_col_seq (
    .clk(clk), .rst_n(rst_n), .mrs_load(mrs_load), .mrs_addr(mrs_addr),
    .start(start), .start_write(start_write), .start_col(start_col),
    .col_ready(col_ready), .col_addr(col_addr), .col_valid(col_valid),
    .col_last(col_last), .burst_done(burst_done), .cfg_error(cfg_error)
  );

  always #5 clk = ~clk;

  typedef struct {
    logic [COLW-1:0] addr;
    logic            last;
    string           req;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // Bench model of the programmed setting
  logic [2:0] m_code = 3'b000;
  logic       m_il   = 1'b0;
  logic       m_sw   = 1'b0;

  bit         stall_en = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
      report();
    end
  end

  // Consumer ready, changed after each rising edge
  always begin
    @(posedge clk);
    #2;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    col_ready = stall_en ? lfsr[0] : 1'b1;
  end

  // Monitor: scoreboard pops, done timing, stall hold
  logic            prev_acc_last = 1'b0;
  logic            prev_v = 1'b0, prev_r = 1'b0, prev_l = 1'b0;
  logic [COLW-1:0] prev_a = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_acc_last || burst_done)
        check(burst_done == prev_acc_last, "R8", "done pulse", burst_done, prev_acc_last);
      if (prev_v && !prev_r)
        check(col_valid && col_addr == prev_a && col_last == prev_l, "R9", "stall hold",
              col_addr, prev_a);
      if (col_valid && col_ready) begin
        if (q.size() == 0) begin
          check(1'b0, "R10", "unexpected beat", col_addr, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(col_addr == e.addr && col_last == e.last, e.req, "beat addr/last",
                {col_last, col_addr}, {e.last, e.addr});
        end
      end
      prev_acc_last = col_valid && col_ready && col_last;
      prev_v = col_valid;
      prev_r = col_ready;
      prev_a = col_addr;
      prev_l = col_last;
    end
  end

  task automatic load_mode(input logic [13:0] a);
    @(posedge clk); #1;
    mrs_addr = a;
    mrs_load = 1'b1;
    @(posedge clk); #1;
    mrs_load = 1'b0;
    m_code = a[2:0];
    m_il   = a[3];
    m_sw   = a[9] && a[8:7] == 2'b00 && a[13:10] == 4'b0000;
  endtask

  task automatic push_model(input logic wr, input logic [COLW-1:0] col, input string req);
    int len;
    case (m_code)
      3'b001:  len = 2;
      3'b010:  len = 4;
      3'b011:  len = 8;
      3'b111:  len = PAGE;
      default: len = 1;
    endcase
    if (wr && m_sw) len = 1;
    for (int i = 0; i < len; i++) begin
      exp_t e;
      int   mask = len - 1;
      int   a;
      if (m_il) a = int'(col) ^ i;
      else      a = (int'(col) & ~mask) | ((int'(col) + i) & mask);
      e.addr = COLW'(a);
      e.last = (i == len - 1);
      e.req  = req;
      q.push_back(e);
    end
  endtask

  task automatic drive_start(input logic wr, input logic [COLW-1:0] col,
                             input string req, input bit do_push);
    @(posedge clk); #1;
    while (col_valid) begin
      @(posedge clk); #1;
    end
    start = 1'b1;
    start_write = wr;
    start_col = col;
    if (do_push) push_model(wr, col, req);
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic drain;
    int n = 0;
    while ((q.size() != 0 || col_valid) && n < 5000) begin
      @(negedge clk);
      n++;
    end
    check(q.size() == 0, "R8", "scoreboard empty", q.size(), 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic run(input logic wr, input logic [COLW-1:0] col, input string req);
    drive_start(wr, col, req, 1'b1);
    drain();
  endtask

  task automatic push_lit(input int a, input bit l, input string req);
    exp_t e;
    e.addr = COLW'(a);
    e.last = l;
    e.req  = req;
    q.push_back(e);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R11: reset state
    check(!col_valid && !col_last && !burst_done && !cfg_error, "R11", "reset outputs",
          {col_valid, col_last, burst_done, cfg_error}, 0);
    run(1'b0, 8'h35, "R11");                         // default: one beat

    load_mode(14'h002);
    run(1'b0, 8'h41, "R2");                          // 41 42 43 40
    run(1'b0, 8'hC6, "R4");
    load_mode(14'h003);
    push_lit(8'h9D, 0, "R2"); push_lit(8'h9E, 0, "R2"); push_lit(8'h9F, 0, "R2");
    push_lit(8'h98, 0, "R2"); push_lit(8'h99, 0, "R2"); push_lit(8'h9A, 0, "R2");
    push_lit(8'h9B, 0, "R2"); push_lit(8'h9C, 1, "R2");
    drive_start(1'b0, 8'h9D, "R2", 1'b0);
    drain();
    load_mode(14'h001);
    run(1'b1, 8'h07, "R1");                          // 07 06

    load_mode(14'h00A);
    run(1'b0, 8'h22, "R3");                          // 22 23 20 21
    load_mode(14'h00B);
    push_lit(8'h15, 0, "R3"); push_lit(8'h14, 0, "R3"); push_lit(8'h17, 0, "R3");
    push_lit(8'h16, 0, "R3"); push_lit(8'h11, 0, "R3"); push_lit(8'h10, 0, "R3");
    push_lit(8'h13, 0, "R3"); push_lit(8'h12, 1, "R3");
    drive_start(1'b0, 8'h15, "R3", 1'b0);
    drain();
    run(1'b0, 8'hEA, "R4");
    load_mode(14'h009);
    run(1'b0, 8'h5B, "R3");

    load_mode(14'h004); run(1'b0, 8'h3C, "R1");      // reserved codes: one beat
    load_mode(14'h00D); run(1'b0, 8'h3D, "R1");
    load_mode(14'h006); run(1'b1, 8'h3E, "R1");

    // R5: full page with back-pressure
    load_mode(14'h007);
    stall_en = 1'b1;
    run(1'b0, 8'hF0, "R5");
    stall_en = 1'b0;

    // R6: full page interleaved is refused
    load_mode(14'h00F);
    drive_start(1'b0, 8'h10, "R6", 1'b0);
    @(negedge clk);
    check(cfg_error && !col_valid, "R6", "error pulse, no beat", {cfg_error, col_valid}, 2'b10);
    @(negedge clk);
    check(!cfg_error && !col_valid, "R6", "error one cycle", {cfg_error, col_valid}, 2'b00);
    repeat (3) @(negedge clk);
    check(q.size() == 0 && !col_valid, "R6", "no burst", col_valid, 0);

    // R7: single-write mode
    load_mode(14'h203);
    run(1'b1, 8'h12, "R7");
    run(1'b0, 8'h12, "R7");
    load_mode(14'h283);                              // A7 set: normal mode
    run(1'b1, 8'h2A, "R7");
    load_mode(14'h60A);                              // A10 set: normal mode
    run(1'b1, 8'h31, "R7");

    // R9: back-pressure on an interleaved burst
    load_mode(14'h00B);
    stall_en = 1'b1;
    run(1'b0, 8'h63, "R9");
    run(1'b1, 8'h6E, "R9");
    stall_en = 1'b0;

    // R10: start during a running burst is ignored
    load_mode(14'h003);
    drive_start(1'b0, 8'hA4, "R10", 1'b1);
    @(posedge clk); #1;
    start = 1'b1; start_write = 1'b0; start_col = 8'h77;
    @(posedge clk); #1;
    start = 1'b0;
    drain();
    repeat (4) @(negedge clk);
    check(!col_valid && q.size() == 0, "R10", "no extra burst", col_valid, 0);

    // R12: mode load mid-burst leaves the burst alone
    drive_start(1'b0, 8'h51, "R12", 1'b1);
    load_mode(14'h00A);
    drain();
    run(1'b0, 8'h51, "R12");                         // new setting applies next time

    report();
  end

endmodule